// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block moves an 18-bit word between two buses, side A and side B, with one independent path for each direction. Each path holds one storage word. Its latch enable makes the path see-through. Its strobe input captures a word on a falling transition. Otherwise the stored word stays where it is. Each path has its own output enable, and the two enables use opposite polarities: the A-to-B enable is active high and the B-to-A enable is active low.

The chip-level tri-state pads sit outside the block. Each side is therefore presented as an input vector, an output vector and an output-enable vector. While a side's enable is off, its output vector reads zero and its enable vector is all zeros. Each side also has a "driven" flag. When that flag is low, the path uses the last word sampled while the side was driven, which models bus hold. The strobe inputs are treated as data: they are sampled on the system clock, and a falling transition is a strobe seen high at one clock edge and low at the next.

Top module: `ubx_bidir_xcvr`

## Requirements
- R1: Each path carries WIDTH bits (default 18) without inversion. Every output bit equals the corresponding bit of the selected word.
- R2: While a path's latch enable is high and its output is enabled, the output equals the effective input of the source side in the same cycle (see-through).
- R3: While the latch enable is low and the strobe shows no high-to-low transition, the stored word does not change, whether the strobe rests high or rests low.
- R4: With the latch enable low, a strobe sampled high at one clock edge and low at the next loads the effective input into storage at that second edge. A low-to-high transition loads nothing.
- R5: A clock edge at which the latch enable is high loads the effective input into storage, and this wins over any strobe transition at that edge. After the enable drops, the output keeps the last word seen through the path.
- R6: The A-to-B enable is active high. While it is low, b_out is zero and b_oe is all zeros, also during reset. While it is high, b_oe is all ones.
- R7: The B-to-A enable is active low. While it is high, a_out is zero and a_oe is all zeros, also during reset. While it is low, a_oe is all ones.
- R8: While a side's driven flag is low, its path uses the word sampled at the last clock edge where that flag was high, and ignores the live input.
- R9: The two paths are independent. Activity on one path's controls and data leaves the other path's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (strobe samplers only) |
| a_in | input | WIDTH | Side A receive data |
| a_drv | input | 1 | Side A input is being driven |
| a_out | output | WIDTH | Side A transmit data (B-to-A path) |
| a_oe | output | WIDTH | Side A per-bit output enable |
| b_in | input | WIDTH | Side B receive data |
| b_drv | input | 1 | Side B input is being driven |
| b_out | output | WIDTH | Side B transmit data (A-to-B path) |
| b_oe | output | WIDTH | Side B per-bit output enable |
| le_ab | input | 1 | A-to-B latch enable, high = see-through |
| cp_ab | input | 1 | A-to-B capture strobe, falling transition captures |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, high = see-through |
| cp_ba | input | 1 | B-to-A capture strobe, falling transition captures |
| oe_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
The embedded properties check, on every cycle, that the output goes quiet whenever its enable is inactive, and that the enable polarity of each side is correct. They also check that the see-through output matches the effective input, that storage stays unchanged when there is no strobe fall, that a fall or an open latch loads the effective input, and that an undriven side falls back to its held word. The bench scenarios are the only means of showing the multi-cycle behaviours at the ports. These are that a rising strobe or a strobe resting at either level captures nothing, that the latch enable wins over a simultaneous strobe fall, and that a stored word survives an output-disable interval. They also show that the two paths do not disturb each other.

// File: rtl/ubx_pkg.sv
`timescale 1ns/1ps
package ubx_pkg;
  localparam int unsigned UBX_WIDTH = 18;

  typedef enum logic {
    OE_ACT_HIGH = 1'b0,
    OE_ACT_LOW  = 1'b1
  } oe_pol_e;
endpackage

// File: rtl/ubx_fall_det.sv
`timescale 1ns/1ps
module ubx_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;
  logic strobe_d;

  always_comb begin
    strobe_d = strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign fall = strobe_q & ~strobe;

  // R4: a detected fall means the strobe was high at the previous edge
  a_r4_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(strobe) && !strobe));
endmodule

// File: rtl/ubx_bus_hold.sv
`timescale 1ns/1ps
module ubx_bus_hold #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             driven,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] keep_q;
  logic [WIDTH-1:0] keep_d;
  logic             keep_en;

  always_comb begin
    keep_en = driven;
    keep_d  = din;
  end

  always_ff @(posedge clk) begin
    if (keep_en) keep_q <= keep_d;
  end

  assign dout = driven ? din : keep_q;

  // R8: after a driven cycle, an undriven side presents the last driven word
  a_r8_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    driven |=> (driven || dout == $past(din)));
endmodule

// File: rtl/ubx_path.sv
`timescale 1ns/1ps
module ubx_path
  import ubx_pkg::*;
#(
  parameter int unsigned WIDTH  = 18,
  parameter oe_pol_e     OE_POL = OE_ACT_HIGH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_in,
  input  logic             src_drv,
  input  logic             le,
  input  logic             strobe,
  input  logic             oe_pin,
  output logic [WIDTH-1:0] dst_out,
  output logic [WIDTH-1:0] dst_oe
);
  logic [WIDTH-1:0] eff_in;
  logic             fall;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             store_en;
  logic [WIDTH-1:0] sel_word;
  logic             oe_on;

  ubx_bus_hold #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (src_in),
    .driven (src_drv),
    .dout   (eff_in)
  );

  ubx_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .fall   (fall)
  );

  always_comb begin
    store_en = le | fall;
    store_d  = eff_in;
  end

  always_ff @(posedge clk) begin
    if (store_en) store_q <= store_d;
  end

  generate
    if (OE_POL == OE_ACT_LOW) begin : g_oe_low
      assign oe_on = ~oe_pin;
    end else begin : g_oe_high
      assign oe_on = oe_pin;
    end
  endgenerate

  always_comb begin
    sel_word = le ? eff_in : store_q;
    dst_out  = oe_on ? sel_word : '0;
    dst_oe   = {WIDTH{oe_on}};
  end

  // R2: see-through output follows the effective input
  a_r2_see_through: assert property (@(posedge clk) disable iff (!rst_n)
    (le && oe_on) |-> dst_out == eff_in);
  // R3: no open latch and no fall keeps storage unchanged
  a_r3_hold_static: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !fall) |=> $stable(store_q));
  // R4: a fall with the latch closed loads the effective input
  a_r4_capture_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && fall) |=> store_q == $past(eff_in));
  // R5: an open latch loads storage at each edge
  a_r5_le_loads: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> store_q == $past(eff_in));
  // R6 / R7: a disabled side drives nothing
  a_r6_quiet_off: assert property (@(posedge clk)
    !oe_on |-> (dst_out == '0 && dst_oe == '0));
endmodule

// File: rtl/ubx_bidir_xcvr.sv
`timescale 1ns/1ps
module ubx_bidir_xcvr
  import ubx_pkg::*;
#(
  parameter int unsigned WIDTH = UBX_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_drv,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_drv,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             le_ab,
  input  logic             cp_ab,
  input  logic             oe_ab,
  input  logic             le_ba,
  input  logic             cp_ba,
  input  logic             oe_ba_n
);
  localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

  ubx_path #(.WIDTH(WIDTH), .OE_POL(OE_ACT_HIGH)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (a_in),
    .src_drv (a_drv),
    .le      (le_ab),
    .strobe  (cp_ab),
    .oe_pin  (oe_ab),
    .dst_out (b_out),
    .dst_oe  (b_oe)
  );

  ubx_path #(.WIDTH(WIDTH), .OE_POL(OE_ACT_LOW)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (b_in),
    .src_drv (b_drv),
    .le      (le_ba),
    .strobe  (cp_ba),
    .oe_pin  (oe_ba_n),
    .dst_out (a_out),
    .dst_oe  (a_oe)
  );

  // R6: side B enable is active high
  a_r6_b_pol: assert property (@(posedge clk)
    oe_ab ? (b_oe == ALL_ON) : (b_oe == '0));
  // R7: side A enable is active low
  a_r7_a_pol: assert property (@(posedge clk)
    oe_ba_n ? (a_oe == '0) : (a_oe == ALL_ON));
endmodule

// File: tb/test_ubx_bidir_xcvr.sv
`timescale 1ns/1ps
module test_ubx_bidir_xcvr;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;
  logic a_drv, b_drv, le_ab, cp_ab, oe_ab, le_ba, cp_ba, oe_ba_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] q_b[$];
  logic [W-1:0] q_a[$];
  logic         q_boe[$];
  logic         q_aoe[$];
  string        q_rid[$];

  always #4 clk = ~clk;

  ubx_bidir_xcvr #(.WIDTH(W)) i_ubx_bidir_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .le_ab(le_ab), .cp_ab(cp_ab), .oe_ab(oe_ab),
    .le_ba(le_ba), .cp_ba(cp_ba), .oe_ba_n(oe_ba_n)
  );

  // driver side: expected outputs after the coming clock edge
  task automatic expect_next(string rid, logic [W-1:0] eb, logic eboe,
                             logic [W-1:0] ea, logic eaoe);
    q_b.push_back(eb);
    q_boe.push_back(eboe);
    q_a.push_back(ea);
    q_aoe.push_back(eaoe);
    q_rid.push_back(rid);
  endtask

  // monitor: compare one scoreboard item per clock edge
  always @(posedge clk) begin
    #1;
    if (q_rid.size() > 0) begin
      automatic string rid = q_rid.pop_front();
      automatic logic [W-1:0] eb = q_b.pop_front();
      automatic logic [W-1:0] ea = q_a.pop_front();
      automatic logic [W-1:0] eboe = {W{q_boe.pop_front()}};
      automatic logic [W-1:0] eaoe = {W{q_aoe.pop_front()}};
      checks += 2;
      if (b_out !== eb || b_oe !== eboe) begin
        errors++;
        $display("FAIL %s side B: out=%h oe=%h expected out=%h oe=%h",
                 rid, b_out, b_oe, eb, eboe);
      end
      if (a_out !== ea || a_oe !== eaoe) begin
        errors++;
        $display("FAIL %s side A: out=%h oe=%h expected out=%h oe=%h",
                 rid, a_out, a_oe, ea, eaoe);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0; a_drv = 1'b1; b_drv = 1'b1;
    le_ab = 1'b0; cp_ab = 1'b0; oe_ab = 1'b0;
    le_ba = 1'b0; cp_ba = 1'b0; oe_ba_n = 1'b1;

    // reset state: both sides quiet (R6, R7)
    @(negedge clk); expect_next("R6 reset", '0, 1'b0, '0, 1'b0);
    @(negedge clk); expect_next("R7 reset", '0, 1'b0, '0, 1'b0);

    // A-to-B see-through (R1, R2)
    @(negedge clk); rst_n = 1'b1; oe_ab = 1'b1; le_ab = 1'b1; a_in = 18'h3FFFF;
    expect_next("R2 see-through", 18'h3FFFF, 1'b1, '0, 1'b0);
    @(negedge clk); a_in = 18'h2A5C3;
    expect_next("R1 non-inverting", 18'h2A5C3, 1'b1, '0, 1'b0);
    // latch closes: last seen word kept (R5)
    @(negedge clk); le_ab = 1'b0; a_in = 18'h01234;
    expect_next("R5 close keeps", 18'h2A5C3, 1'b1, '0, 1'b0);
    // rising strobe captures nothing (R4)
    @(negedge clk); cp_ab = 1'b1;
    expect_next("R4 rise no capture", 18'h2A5C3, 1'b1, '0, 1'b0);
    // strobe resting high (R3)
    @(negedge clk); a_in = 18'h15A5A;
    expect_next("R3 static high", 18'h2A5C3, 1'b1, '0, 1'b0);
    // falling strobe captures (R4)
    @(negedge clk); cp_ab = 1'b0; a_in = 18'h0F0F0;
    expect_next("R4 fall capture", 18'h0F0F0, 1'b1, '0, 1'b0);
    // strobe resting low (R3)
    @(negedge clk); a_in = 18'h33333;
    expect_next("R3 static low", 18'h0F0F0, 1'b1, '0, 1'b0);
    // output disable (R6)
    @(negedge clk); oe_ab = 1'b0;
    expect_next("R6 disabled", '0, 1'b0, '0, 1'b0);
    @(negedge clk); oe_ab = 1'b1;
    expect_next("R6 re-enabled keeps word", 18'h0F0F0, 1'b1, '0, 1'b0);
    // bus hold on side A (R8)
    @(negedge clk); le_ab = 1'b1; a_in = 18'h1C71C;
    expect_next("R2 see-through again", 18'h1C71C, 1'b1, '0, 1'b0);
    @(negedge clk); a_drv = 1'b0; a_in = 18'h20001;
    expect_next("R8 undriven A holds", 18'h1C71C, 1'b1, '0, 1'b0);
    @(negedge clk); a_drv = 1'b1;
    expect_next("R8 driven A resumes", 18'h20001, 1'b1, '0, 1'b0);
    // latch enable wins over a strobe fall (R5)
    @(negedge clk); cp_ab = 1'b1;
    expect_next("R5 strobe high open", 18'h20001, 1'b1, '0, 1'b0);
    @(negedge clk); cp_ab = 1'b0; a_in = 18'h12345;
    expect_next("R5 fall while open", 18'h12345, 1'b1, '0, 1'b0);
    @(negedge clk); le_ab = 1'b0; a_in = 18'h3ABCD;
    expect_next("R5 precedence kept", 18'h12345, 1'b1, '0, 1'b0);

    // B-to-A path, active-low enable (R7, R9)
    @(negedge clk); oe_ba_n = 1'b0; le_ba = 1'b1; b_in = 18'h00001;
    expect_next("R7 enable low drives A", 18'h12345, 1'b1, 18'h00001, 1'b1);
    @(negedge clk); le_ba = 1'b0; cp_ba = 1'b1; b_in = 18'h2FFFE;
    expect_next("R9 B rise holds, B side unaffected", 18'h12345, 1'b1, 18'h00001, 1'b1);
    @(negedge clk); cp_ba = 1'b0; b_in = 18'h1E1E1;
    expect_next("R4 B fall capture", 18'h12345, 1'b1, 18'h1E1E1, 1'b1);
    @(negedge clk); oe_ba_n = 1'b1;
    expect_next("R7 enable high quiets A", 18'h12345, 1'b1, '0, 1'b0);
    @(negedge clk); oe_ba_n = 1'b0; le_ba = 1'b1; b_drv = 1'b0; b_in = 18'h0AAAA;
    expect_next("R8 undriven B holds", 18'h12345, 1'b1, 18'h1E1E1, 1'b1);
    // A path activity does not touch side A output (R9)
    @(negedge clk); cp_ab = 1'b1; a_in = 18'h00F00;
    expect_next("R9 A strobe rise", 18'h12345, 1'b1, 18'h1E1E1, 1'b1);
    @(negedge clk); cp_ab = 1'b0;
    expect_next("R9 A fall, A side unchanged", 18'h00F00, 1'b1, 18'h1E1E1, 1'b1);

    @(negedge clk);
    @(negedge clk);
    if (q_rid.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_rid.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule